// File: doc/BRIEF.md
# Receiver DC Offset Calibration Controller

This controller removes static DC offset from a direct-conversion receiver. It sets two separate correction codes, one for the in-phase path and one for the quadrature path. It finds each code by averaging digitized baseband samples and running a successive-approximation search on the sign of the mean. Each resulting code pair is stored in a table with one entry for every combination of receive gain index and RF channel index. While the controller is idle, it presents the entry for the live gain and channel selects to the correction DACs.

A start pulse with `refresh` low runs a full sweep. This sweep covers every gain index on the channel presented at start, and the host repeats it once per channel after power-up. A start pulse with `refresh` high runs a short recalibration of only the highest-gain entries on the current channel, so that it fits in the gap between frames. An abort input stops either kind of run at once. This is used when a frame arrives.

The controller has six states. From IDLE, start goes to LOAD. LOAD clears the codes and arms the MSB and then goes to TRIAL. TRIAL sets the trial bit and clears the averagers, then goes to ACC. ACC collects the window of samples and goes to DECIDE when the window is full. DECIDE keeps or drops the trial bit. It goes back to TRIAL for the next lower bit, or to STORE after the LSB. STORE writes the entry. It then goes to LOAD for the next gain, or to IDLE with a done pulse after the last gain. From any busy state, abort goes to IDLE.

Top module: `rx_offset_cal`

## Requirements
- R1: After reset, busy and done are low and every table entry holds midscale 128 for both paths, so the DAC outputs read 128 for any select.
- R2: When idle, `rx_gain` equals `gain_sel`. `dac_i`/`dac_q` show the stored entry for `gain_sel`/`chan_sel` one clock after the selects change.
- R3: A full sweep (`refresh`=0 at start) calibrates gain indices 0 to NGAIN-1 in ascending order, on the channel sampled at start. While busy it drives the index under calibration on `rx_gain`.
- R4: The I and Q codes are searched in parallel and independently, MSB first. Each step sets the trial bit and keeps it only if the averaged offset is strictly positive. The result is the largest code whose mean is positive, or 0 if no code gives a positive mean.
- R5: Each step averages exactly 2^AVG_LOG2 samples taken while `samp_valid` is high, as the accumulated sum arithmetically shifted right by AVG_LOG2. Samples with `samp_valid` low are ignored.
- R6: A refresh (`refresh`=1 at start) calibrates only the top HI_CNT gain indices, in ascending order, on the current channel. All other entries are left unchanged.
- R7: Abort while busy returns the controller to idle on the next clock with no done pulse. The entry in progress keeps its previous value. Entries finished earlier in that run keep their new values.
- R8: Done is a single-cycle pulse after the last entry is written. A start pulse while busy is ignored.
- R9: A calibration writes only entries of its own channel. Entries of other channels are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a calibration when idle |
| refresh | input | 1 | Sampled at start: 1 = high-gain refresh, 0 = full sweep |
| abort | input | 1 | Ends a running calibration |
| gain_sel | input | GAIN_W (3) | Live receive gain index |
| chan_sel | input | CHAN_W (4) | Live RF channel index |
| samp_valid | input | 1 | Baseband sample strobe |
| samp_i | input | SAMP_W (10) | Signed I sample |
| samp_q | input | SAMP_W (10) | Signed Q sample |
| dac_i | output | CODE_W (8) | I offset-correction code |
| dac_q | output | CODE_W (8) | Q offset-correction code |
| rx_gain | output | GAIN_W (3) | Gain index to apply to the receiver |
| busy | output | 1 | Calibration running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle the following properties. Done only follows a busy cycle. Abort always ends a run with no done. A refresh never drives a gain index below the high-gain range. The search mask is never more than one-hot. The bench alone can show that the converged codes are right. It does this with a closed-loop model of the analog offset, and that model includes saturated codes at both ends and ignored invalid samples. It also shows the gain visiting order, the partial table update after an abort, and that other channels are left alone.

// File: rtl/rxoc_pkg.sv
package rxoc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_TRIAL,
        ST_ACC,
        ST_DECIDE,
        ST_STORE
    } cal_state_t;

    localparam int NUM_PATHS = 2;
endpackage

// File: rtl/rxoc_path.sv
module rxoc_path #(
    parameter int SAMP_W   = 10,
    parameter int AVG_LOG2 = 6,
    parameter int CODE_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init,
    input  logic                     set_bit,
    input  logic                     decide,
    input  logic                     acc_en,
    input  logic [CODE_W-1:0]        mask,
    input  logic signed [SAMP_W-1:0] samp,
    output logic [CODE_W-1:0]        code
);
    localparam int ACC_W = SAMP_W + AVG_LOG2;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] mean;
    logic                    mean_pos;

    assign mean     = acc >>> AVG_LOG2;
    assign mean_pos = (mean > 0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (init || set_bit) begin
            acc <= '0;
        end else if (acc_en) begin
            acc <= acc + {{AVG_LOG2{samp[SAMP_W-1]}}, samp};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
        end else if (init) begin
            code <= '0;
        end else if (set_bit) begin
            code <= code | mask;
        end else if (decide && !mean_pos) begin
            code <= code & ~mask;
        end
    end

    // R4: a decided bit that was kept leaves the code unchanged
    p_keep_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && mean_pos && !init && !set_bit) |=> (code == $past(code)));
endmodule

// File: rtl/rxoc_table.sv
module rxoc_table #(
    parameter int CODE_W = 8,
    parameter int GAIN_W = 3,
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [GAIN_W-1:0] wgain,
    input  logic [CHAN_W-1:0] wchan,
    input  logic [CODE_W-1:0] wcode_i,
    input  logic [CODE_W-1:0] wcode_q,
    input  logic [GAIN_W-1:0] rgain,
    input  logic [CHAN_W-1:0] rchan,
    output logic [CODE_W-1:0] rcode_i,
    output logic [CODE_W-1:0] rcode_q
);
    localparam int NENT = 1 << (GAIN_W + CHAN_W);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

    logic [2*CODE_W-1:0] mem [NENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NENT; k++) mem[k] <= {MID, MID};
        end else if (we) begin
            mem[{wgain, wchan}] <= {wcode_i, wcode_q};
        end
    end

    assign {rcode_i, rcode_q} = mem[{rgain, rchan}];
endmodule

// File: rtl/rx_offset_cal.sv
module rx_offset_cal #(
    parameter int CODE_W   = 8,
    parameter int SAMP_W   = 10,
    parameter int AVG_LOG2 = 6,
    parameter int NGAIN    = 8,
    parameter int NCHAN    = 16,
    parameter int HI_CNT   = 2,
    parameter int GAIN_W   = $clog2(NGAIN),
    parameter int CHAN_W   = $clog2(NCHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              refresh,
    input  logic              abort,
    input  logic [GAIN_W-1:0] gain_sel,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic              samp_valid,
    input  logic [SAMP_W-1:0] samp_i,
    input  logic [SAMP_W-1:0] samp_q,
    output logic [CODE_W-1:0] dac_i,
    output logic [CODE_W-1:0] dac_q,
    output logic [GAIN_W-1:0] rx_gain,
    output logic              busy,
    output logic              done
);
    import rxoc_pkg::*;

    localparam logic [GAIN_W-1:0]   GLAST    = GAIN_W'(NGAIN - 1);
    localparam logic [GAIN_W-1:0]   HI_FIRST = GAIN_W'(NGAIN - HI_CNT);
    localparam logic [AVG_LOG2-1:0] SLAST    = '1;
    localparam logic [CODE_W-1:0]   MSB_MASK = CODE_W'(1 << (CODE_W - 1));

    cal_state_t state, nxt;

    logic [GAIN_W-1:0]   cur_gain;
    logic [CHAN_W-1:0]   cal_chan;
    logic                refresh_r;
    logic [CODE_W-1:0]   mask;
    logic [AVG_LOG2-1:0] scnt;
    logic [CODE_W-1:0]   live_i, live_q;
    logic [CODE_W-1:0]   rd_i, rd_q;

    logic path_init, set_bit, decide, acc_en, tab_we, win_full;

    logic [SAMP_W-1:0] samp_arr [NUM_PATHS];
    logic [CODE_W-1:0] code_arr [NUM_PATHS];

    assign samp_arr[0] = samp_i;
    assign samp_arr[1] = samp_q;

    assign busy      = (state != ST_IDLE);
    assign path_init = (state == ST_LOAD);
    assign set_bit   = (state == ST_TRIAL);
    assign decide    = (state == ST_DECIDE);
    assign acc_en    = (state == ST_ACC) && samp_valid;
    assign win_full  = acc_en && (scnt == SLAST);
    assign tab_we    = (state == ST_STORE) && !abort;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (busy && abort) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (start) nxt = ST_LOAD;
                ST_LOAD:   nxt = ST_TRIAL;
                ST_TRIAL:  nxt = ST_ACC;
                ST_ACC:    if (win_full) nxt = ST_DECIDE;
                ST_DECIDE: nxt = mask[0] ? ST_STORE : ST_TRIAL;
                ST_STORE:  nxt = (cur_gain == GLAST) ? ST_IDLE : ST_LOAD;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // sequencing registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_gain  <= '0;
            cal_chan  <= '0;
            refresh_r <= 1'b0;
            mask      <= '0;
            scnt      <= '0;
            done      <= 1'b0;
            live_i    <= MSB_MASK;
            live_q    <= MSB_MASK;
        end else begin
            live_i <= rd_i;
            live_q <= rd_q;
            done   <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    cur_gain  <= refresh ? HI_FIRST : '0;
                    cal_chan  <= chan_sel;
                    refresh_r <= refresh;
                end
                ST_LOAD:   mask <= MSB_MASK;
                ST_TRIAL:  scnt <= '0;
                ST_ACC:    if (acc_en) scnt <= scnt + 1'b1;
                ST_DECIDE: mask <= mask >> 1;
                ST_STORE: if (!abort) begin
                    if (cur_gain == GLAST) done <= 1'b1;
                    else                   cur_gain <= cur_gain + 1'b1;
                end
                default: ;
            endcase
        end
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        rxoc_path #(
            .SAMP_W  (SAMP_W),
            .AVG_LOG2(AVG_LOG2),
            .CODE_W  (CODE_W)
        ) u_path (
            .clk    (clk),
            .rst_n  (rst_n),
            .init   (path_init),
            .set_bit(set_bit),
            .decide (decide),
            .acc_en (acc_en),
            .mask   (mask),
            .samp   (samp_arr[p]),
            .code   (code_arr[p])
        );
    end

    rxoc_table #(
        .CODE_W(CODE_W),
        .GAIN_W(GAIN_W),
        .CHAN_W(CHAN_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tab_we),
        .wgain  (cur_gain),
        .wchan  (cal_chan),
        .wcode_i(code_arr[0]),
        .wcode_q(code_arr[1]),
        .rgain  (gain_sel),
        .rchan  (chan_sel),
        .rcode_i(rd_i),
        .rcode_q(rd_q)
    );

    assign dac_i   = busy ? code_arr[0] : live_i;
    assign dac_q   = busy ? code_arr[1] : live_q;
    assign rx_gain = busy ? cur_gain : gain_sel;

    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    p_abort_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && !done));

    p_refresh_high_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && refresh_r) |-> (rx_gain >= HI_FIRST));

    p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask));

    p_run_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort && state != ST_STORE) |=> busy);
endmodule

// File: tb/rx_offset_cal_bench.sv
module rx_offset_cal_bench;
    localparam int NG = 8;
    localparam int NC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, refresh = 1'b0, abort = 1'b0;
    logic [2:0] gain_sel = '0;
    logic [3:0] chan_sel = '0;
    logic       samp_valid = 1'b0;
    logic [9:0] samp_i = '0, samp_q = '0;
    logic [7:0] dac_i, dac_q;
    logic [2:0] rx_gain;
    logic       busy, done;

    int checks = 0, failures = 0;
    int drift = 0;
    int cyc = 0;
    int nz = 1;
    int exp_i [NG*NC];
    int exp_q [NG*NC];
    int gq [$];
    bit prev_busy = 1'b0;
    int prev_gain = -1;

    always #2 clk = ~clk;

    rx_offset_cal u_rx_offset_cal (
        .clk(clk), .rst_n(rst_n), .start(start), .refresh(refresh), .abort(abort),
        .gain_sel(gain_sel), .chan_sel(chan_sel), .samp_valid(samp_valid),
        .samp_i(samp_i), .samp_q(samp_q), .dac_i(dac_i), .dac_q(dac_q),
        .rx_gain(rx_gain), .busy(busy), .done(done));

    function automatic int off_i(int g, int c);
        if (c == 15) return 300;
        if (c == 14) return -200;
        return ((g*37 + c*11) % 160) - 80;
    endfunction

    function automatic int off_q(int g, int c);
        if (c == 14) return -200;
        if (c == 15) return 0;
        return ((g*53 + c*29) % 150) - 75;
    endfunction

    function automatic int clampc(int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // analog model: residual offset falls by one LSB per code step; invalid samples carry junk (R5)
    always @(negedge clk) begin
        int vi, vq;
        cyc++;
        if (cyc % 3 != 0) begin
            nz = -nz;
            vi = off_i(rx_gain, chan_sel) + drift - (int'(dac_i) - 128) + nz;
            vq = off_q(rx_gain, chan_sel) + drift - (int'(dac_q) - 128) - nz;
            samp_valid <= 1'b1;
            samp_i <= vi[9:0];
            samp_q <= vq[9:0];
        end else begin
            samp_valid <= 1'b0;
            samp_i <= 10'h1FF;
            samp_q <= 10'h200;
        end
    end

    // monitor: gain visiting order against the scoreboard queue (R3, R6)
    always @(negedge clk) begin
        if (rst_n && busy && (!prev_busy || int'(rx_gain) != prev_gain)) begin
            if (gq.size() == 0) begin
                check(1'b0, "R3/R6 unexpected gain visit", int'(rx_gain), -1);
            end else begin
                int e;
                e = gq.pop_front();
                check(int'(rx_gain) == e, "R3/R6 gain order", int'(rx_gain), e);
            end
        end
        prev_busy = busy;
        prev_gain = busy ? int'(rx_gain) : -1;
    end

    task automatic read_entry(int g, int c, string req);
        gain_sel = 3'(g);
        chan_sel = 4'(c);
        @(posedge clk);
        @(negedge clk);
        check(rx_gain == 3'(g), "R2 rx_gain follows gain_sel", int'(rx_gain), g);
        check(int'(dac_i) == exp_i[g*NC+c], {req, " I code"}, int'(dac_i), exp_i[g*NC+c]);
        check(int'(dac_q) == exp_q[g*NC+c], {req, " Q code"}, int'(dac_q), exp_q[g*NC+c]);
    endtask

    task automatic check_chan(int c, string req);
        for (int g = 0; g < NG; g++) read_entry(g, c, req);
    endtask

    // driver: pushes expected visits, runs one calibration, updates the model table
    task automatic run_cal(int c, bit refr, int abort_gain, bit start_mid);
        int first, n_done, last_done, cnt;
        first = refr ? NG - 2 : 0;
        gq.delete();
        for (int g = first; g < NG; g++) gq.push_back(g);
        @(negedge clk);
        chan_sel = 4'(c);
        refresh = refr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        refresh = 1'b0;
        n_done = 0;
        last_done = NG;
        cnt = 0;
        while (cnt < 20000) begin
            @(negedge clk);
            cnt++;
            if (done) n_done++;
            if (start_mid && cnt == 500) begin
                start = 1'b1; refresh = 1'b1;   // R8: ignored while busy
            end else begin
                start = 1'b0; refresh = 1'b0;
            end
            if (abort_gain >= 0 && busy && int'(rx_gain) == abort_gain && cnt > 0) begin
                repeat (200) @(negedge clk);
                abort = 1'b1;
                @(negedge clk);
                abort = 1'b0;
                check(!busy && !done, "R7 abort ends run", int'(busy), 0);
                last_done = abort_gain;
                break;
            end
            if (!busy) break;
        end
        repeat (3) begin
            @(negedge clk);
            if (done) n_done++;
        end
        check(n_done == ((abort_gain >= 0) ? 0 : 1), "R8 done pulse count", n_done,
              (abort_gain >= 0) ? 0 : 1);
        check(gq.size() == 0, "R3/R6 all gains visited", gq.size(), 0);
        for (int g = first; g < last_done; g++) begin
            exp_i[g*NC+c] = clampc(off_i(g, c) + drift + 127);
            exp_q[g*NC+c] = clampc(off_q(g, c) + drift + 127);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < NG*NC; k++) begin exp_i[k] = 128; exp_q[k] = 128; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1 idle after reset", int'(busy), 0);
        read_entry(0, 0, "R1 reset midscale");
        read_entry(7, 9, "R1 reset midscale");
        // R3, R4, R5: full sweep on an ordinary channel
        run_cal(3, 1'b0, -1, 1'b0);
        check_chan(3, "R4 R5 converged codes ch3");
        // R4: codes saturating high (I) and at mid (Q)
        run_cal(15, 1'b0, -1, 1'b0);
        check_chan(15, "R4 saturated high ch15");
        // R4: no positive mean gives code 0; R8 start during a run is ignored
        run_cal(14, 1'b0, -1, 1'b1);
        check_chan(14, "R4 R8 saturated low ch14");
        // R9: an uncalibrated channel stays at midscale
        check_chan(0, "R9 other channel untouched");
        // R6: refresh updates only the top gains of the current channel
        drift = 5;
        run_cal(3, 1'b1, -1, 1'b0);
        check_chan(3, "R6 refresh ch3");
        check_chan(15, "R9 ch15 kept after refresh");
        // R7: abort during the last gain keeps its old entry
        drift = 9;
        run_cal(3, 1'b1, 7, 1'b0);
        check_chan(3, "R7 abort partial update ch3");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule